// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the single-bit output of a sigma-delta modulator into filtered multi-bit words. Each modulator bit arrives with a one-cycle sample strobe. Three cascaded integrators run at the sample rate. Every N accepted samples, a chain of three comb stages runs once. The result is a sinc-cubed response whose first notch, and therefore whose word rate, is the sample rate divided by N.

N is a 12-bit rate code. A code written by the host is only stored as pending. It takes effect at the next filter restart. A restart is caused by the active-low `restart_n` input or by any change on `chan_sel`. A restart clears all integrator, comb and counter state. `dout_vld` is then withheld until the third output period, which is the first one whose data window lies entirely after the restart.

Words are presented as 24-bit values or as a narrowed 16-bit value. They use unipolar straight binary or bipolar offset-binary coding. Both choices are sampled live at each output boundary.

Top module: `sinc3_decim`

## Requirements
- R1: The raw 34-bit result R at an output boundary equals the sum of the accepted input bits since the last restart (0 or 1), weighted by the triple-boxcar kernel of length 3N-2. For a constant input b over three whole periods, R = b·N³.
- R2: An output boundary occurs on every N-th accepted strobe after a restart. At a settled boundary, `dout_vld` is high for exactly the one clock cycle that follows the edge on which that strobe was sampled.
- R3: A written rate code in the range 19 to 2000 inclusive becomes pending. The active code changes only at the next restart. After `rst_n`, the active and pending code is the parameter RATE_DEFAULT.
- R4: A written code outside 19..2000 is ignored and the previous pending code is kept. `rate_err` rises on the next cycle and stays high until `rst_n`.
- R5: After `rst_n` or a cycle with `restart_n` low, the first two boundaries do not raise `dout_vld`. The third and every later boundary do.
- R6: A change of `chan_sel` causes the same restart as `restart_n` low, including the three-period settling.
- R7: In unipolar mode (`unipolar`=1), the 24-bit word is R[33:10].
- R8: In bipolar mode (`unipolar`=0), the 24-bit word is ((2R − N³) arithmetically shifted right by 10) + 2²³, modulo 2²⁴. Half-scale input therefore maps near 0x800000.
- R9: With `wide_word`=1, `dout` carries the 24-bit word. With `wide_word`=0, `dout[15:0]` is bits 23:8 of that word and `dout[23:16]` is zero.
- R10: Clock cycles without `mod_stb` leave the filter unchanged and never raise `dout_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator bit |
| mod_stb | input | 1 | Sample strobe qualifying `mod_bit` |
| rate_code | input | 12 | Decimation ratio to store |
| rate_wr | input | 1 | Write strobe for `rate_code` |
| restart_n | input | 1 | Active-low synchronous filter restart |
| chan_sel | input | 1 | Channel select; any change restarts the filter |
| wide_word | input | 1 | 1: 24-bit word, 0: 16-bit word |
| unipolar | input | 1 | 1: unipolar coding, 0: bipolar offset binary |
| dout | output | 24 | Output word |
| dout_vld | output | 1 | One-cycle valid pulse for `dout` |
| rate_err | output | 1 | Sticky flag for an out-of-range rate code |

## Verification
Some properties are checked by assertions on every cycle. These are: the active code stays in range and changes only on a restart; the sample counter stays below the code; the error flag is sticky and raised by a bad write; valid pulses are single-cycle, follow a strobe and never follow a restart; idle cycles hold the integrators; and narrow words keep their top byte at zero. Other behaviour needs the bench scenarios. These cover the numeric result against an independently computed triple-boxcar convolution, both codings and both widths, and the settling count after restarts from reset, from `restart_n`, mid-period and from a channel change. They also check that pending codes apply only after a restart, and the extreme ratios 19, 20 and 2000.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int ORDER    = 3;
    localparam int CODE_W   = 12;
    localparam int ACC_W    = 34;
    localparam int OUT_W    = 24;
    localparam int NARROW_W = 16;
    localparam int CODE_MIN = 19;
    localparam int CODE_MAX = 2000;
    localparam int SHIFT    = ACC_W - OUT_W;
    localparam int SETTLE_W = $clog2(ORDER);

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t               pend;
        code_t               act;
        code_t               cnt;
        logic [SETTLE_W-1:0] settle;
        logic                chan;
        logic                err;
    } ctl_t;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             vld;
    } out_t;

    function automatic logic code_legal(input code_t c);
        return (int'(c) >= CODE_MIN) && (int'(c) <= CODE_MAX);
    endfunction
endpackage

// File: rtl/sinc3_rate_ctl.sv
module sinc3_rate_ctl
    import sinc3_pkg::*;
#(
    parameter int RATE_DEFAULT = 24
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  code_t rate_code,
    input  logic  rate_wr,
    input  logic  restart_n,
    input  logic  chan_sel,
    output logic  restart,
    output logic  boundary,
    output logic  settled,
    output code_t active_code,
    output logic  rate_err
);
    localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(ORDER - 1);

    ctl_t s_q, s_d;

    assign restart     = !restart_n || (chan_sel != s_q.chan);
    assign boundary    = !restart && stb && (s_q.cnt == code_t'(s_q.act - 1'b1));
    assign settled     = (s_q.settle == SETTLE_LAST);
    assign active_code = s_q.act;
    assign rate_err    = s_q.err;

    always_comb begin
        s_d = s_q;
        if (rate_wr) begin
            if (code_legal(rate_code)) s_d.pend = rate_code;
            else                       s_d.err  = 1'b1;
        end
        if (restart) begin
            s_d.act    = s_q.pend;
            s_d.cnt    = '0;
            s_d.settle = '0;
            s_d.chan   = chan_sel;
        end else if (stb) begin
            if (boundary) begin
                s_d.cnt = '0;
                if (s_q.settle != SETTLE_LAST) s_d.settle = s_q.settle + 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend   <= code_t'(RATE_DEFAULT);
            s_q.act    <= code_t'(RATE_DEFAULT);
            s_q.cnt    <= '0;
            s_q.settle <= '0;
            s_q.chan   <= 1'b0;
            s_q.err    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    a_r3_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        code_legal(s_q.act));
    a_r3_code_only_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(active_code));
    a_r4_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr && !code_legal(rate_code)) |=> rate_err);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |=> rate_err);
    a_r2_count_below_code: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < s_q.act);
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int STAGES = 3,
    parameter int W      = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] tap
);
    logic [STAGES-1:0][W-1:0] i_q, i_d, sum;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sum[g] = i_q[g] + {{(W-1){1'b0}}, din};
        end else begin : g_rest
            assign sum[g] = i_q[g] + sum[g-1];
        end
    end

    assign tap = sum[STAGES-1];

    always_comb begin
        i_d = i_q;
        if (clear)   i_d = '0;
        else if (en) i_d = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(i_q));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int STAGES = 3,
    parameter int W      = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] result
);
    logic [STAGES-1:0][W-1:0] d_q, d_d, stage_in, diff;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_in[g] = din;
        end else begin : g_rest
            assign stage_in[g] = diff[g-1];
        end
        assign diff[g] = stage_in[g] - d_q[g];
    end

    assign result = diff[STAGES-1];

    always_comb begin
        d_d = d_q;
        if (clear)   d_d = '0;
        else if (en) d_d = stage_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (d_q == '0));
endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt
    import sinc3_pkg::*;
(
    input  acc_t             raw,
    input  acc_t             full,
    input  logic             wide,
    input  logic             unip,
    output logic [OUT_W-1:0] word
);
    logic [OUT_W-1:0] uni_w, bip_w, w24;

    assign uni_w = raw[ACC_W-1:SHIFT];
    assign bip_w = OUT_W'(({raw[ACC_W-2:0], 1'b0} - full) >> SHIFT)
                 ^ {1'b1, {(OUT_W-1){1'b0}}};
    assign w24   = unip ? uni_w : bip_w;

    always_comb begin
        if (wide) word = w24;
        else      word = {{(OUT_W-NARROW_W){1'b0}}, w24[OUT_W-1 -: NARROW_W]};
    end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int RATE_DEFAULT = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mod_bit,
    input  logic                  mod_stb,
    input  logic [CODE_W-1:0]     rate_code,
    input  logic                  rate_wr,
    input  logic                  restart_n,
    input  logic                  chan_sel,
    input  logic                  wide_word,
    input  logic                  unipolar,
    output logic [OUT_W-1:0]      dout,
    output logic                  dout_vld,
    output logic                  rate_err
);
    logic  restart, boundary, settled;
    code_t active_code;
    acc_t  integ_tap, comb_res, full_scale;
    logic [OUT_W-1:0] word;
    out_t  o_q, o_d;

    sinc3_rate_ctl #(.RATE_DEFAULT(RATE_DEFAULT)) u_ctl (
        .clk, .rst_n, .stb(mod_stb), .rate_code, .rate_wr, .restart_n,
        .chan_sel, .restart, .boundary, .settled, .active_code, .rate_err
    );

    sinc3_integ #(.STAGES(ORDER), .W(ACC_W)) u_integ (
        .clk, .rst_n, .clear(restart), .en(mod_stb), .din(mod_bit), .tap(integ_tap)
    );

    sinc3_comb #(.STAGES(ORDER), .W(ACC_W)) u_comb (
        .clk, .rst_n, .clear(restart), .en(boundary), .din(integ_tap), .result(comb_res)
    );

    always_comb begin
        full_scale = acc_t'(1);
        for (int k = 0; k < ORDER; k++)
            full_scale = acc_t'(full_scale * acc_t'(active_code));
    end

    sinc3_fmt u_fmt (
        .raw(comb_res), .full(full_scale), .wide(wide_word), .unip(unipolar), .word
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = boundary && settled;
        if (boundary) o_d.word = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dout     = o_q.word;
    assign dout_vld = o_q.vld;

    a_r5_no_vld_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !dout_vld);
    a_r2_vld_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |=> !dout_vld);
    a_r10_vld_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_stb |=> !dout_vld);
    a_r9_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && !$past(wide_word)) |-> (dout[OUT_W-1:NARROW_W] == '0));
endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_bit = 1'b0, mod_stb = 1'b0, rate_wr = 1'b0;
    logic restart_n = 1'b1, chan_sel = 1'b0, wide_word = 1'b1, unipolar = 1'b1;
    logic [11:0] rate_code = 12'd0;
    logic [23:0] dout;
    logic dout_vld, rate_err;

    sinc3_decim u0 (
        .clk, .rst_n, .mod_bit, .mod_stb, .rate_code, .rate_wr, .restart_n,
        .chan_sel, .wide_word, .unipolar, .dout, .dout_vld, .rate_err
    );

    always #5 clk = ~clk;

    int nchk = 0, nerr = 0;
    int ncur = 24, npend = 24, nsmp = 0, kb = 0;
    bit big = 0;
    string dtag = "R1";
    longint h2[0:255];
    longint h[0:255];
    bit xs[0:4095];
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void build_kernel();
        for (int i = 0; i < 256; i++) begin h2[i] = 0; h[i] = 0; end
        for (int i = 0; i < 2*ncur-1; i++)
            h2[i] = (i + 1 < 2*ncur - 1 - i) ? i + 1 : 2*ncur - 1 - i;
        for (int i = 0; i < 3*ncur-2; i++)
            for (int a = 0; a < ncur; a++)
                if (i - a >= 0 && i - a < 2*ncur-1) h[i] += h2[i-a];
    endfunction

    function automatic void restart_model();
        ncur = npend; big = (ncur > 60); nsmp = 0; kb = 0;
        if (!big) build_kernel();
    endfunction

    function automatic longint model_r(input bit b);
        longint s = 0;
        longint n3 = longint'(ncur) * ncur * ncur;
        if (big) return b ? n3 : 0;
        for (int j = 0; j < 3*ncur-2; j++)
            if (nsmp - 1 - j >= 0) s += h[j] * xs[nsmp-1-j];
        return s;
    endfunction

    function automatic longint fmt(input longint r);
        longint n3 = longint'(ncur) * ncur * ncur;
        longint w;
        if (unipolar) w = r >> 10;
        else          w = (((2*r - n3) >>> 10) + 64'sd8388608) & 64'hFFFFFF;
        if (!wide_word) w = (w >> 8) & 64'hFFFF;
        return w;
    endfunction

    task automatic send(input bit b, input int gap);
        bit bnd, expv;
        longint w;
        @(negedge clk); mod_bit = b; mod_stb = 1'b1;
        @(negedge clk); mod_stb = 1'b0;
        if (!big) xs[nsmp] = b;
        nsmp++;
        bnd = (nsmp % ncur) == 0;
        if (bnd) kb++;
        expv = bnd && (kb >= 3);
        chk(dout_vld === expv, expv ? "R2 valid at boundary" : "R5 valid withheld",
            longint'(dout_vld), longint'(expv));
        if (expv) begin
            w = fmt(model_r(b));
            chk(dout === w[23:0], dtag, longint'(dout), w);
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(dout_vld === 1'b0, "R10 idle no valid", longint'(dout_vld), 0);
        end
    endtask

    task automatic send_lfsr(input int count, input int gap);
        for (int i = 0; i < count; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(lf[0], gap);
        end
    endtask

    task automatic wr_rate(input int c);
        @(negedge clk); rate_code = 12'(c); rate_wr = 1'b1;
        @(negedge clk); rate_wr = 1'b0;
        if (c >= 19 && c <= 2000) npend = c;
    endtask

    task automatic do_sync();
        @(negedge clk); restart_n = 1'b0;
        @(negedge clk); restart_n = 1'b1;
        restart_model();
    endtask

    task automatic flip_chan();
        @(negedge clk); chan_sel = ~chan_sel;
        restart_model();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        restart_model();
        @(negedge clk);
        chk(dout === 24'd0, "R2 reset word", longint'(dout), 0);
        chk(dout_vld === 1'b0, "R2 reset valid", longint'(dout_vld), 0);
        chk(rate_err === 1'b0, "R4 reset flag", longint'(rate_err), 0);

        // R1/R7: constant ones at the default ratio, unipolar 24-bit
        dtag = "R1 R7 constant ones";
        for (int i = 0; i < 4*24; i++) send(1'b1, 0);

        // R4: illegal codes are ignored and raise the sticky flag
        wr_rate(18);
        chk(rate_err === 1'b1, "R4 code 18 flagged", longint'(rate_err), 1);
        wr_rate(2001); wr_rate(0); wr_rate(4095);
        @(negedge clk);
        chk(rate_err === 1'b1, "R4 flag sticky", longint'(rate_err), 1);
        do_sync();
        dtag = "R4 ratio kept after bad codes";
        send_lfsr(4*24, 0);

        // R3: legal code pending until restart
        wr_rate(19);
        dtag = "R3 old ratio before restart";
        send_lfsr(2*24, 0);
        do_sync();
        dtag = "R1 R7 ratio 19 stream";
        send_lfsr(8*19, 0);

        // R6 + R8: channel change restart, bipolar
        wr_rate(20);
        flip_chan();
        unipolar = 1'b0;
        dtag = "R6 R8 bipolar after channel change";
        send_lfsr(5*20, 0);

        // R9: narrow words, both codings
        wide_word = 1'b0;
        dtag = "R9 narrow bipolar";
        send_lfsr(2*20, 0);
        unipolar = 1'b1;
        dtag = "R9 narrow unipolar";
        send_lfsr(2*20, 0);
        wide_word = 1'b1;
        unipolar = 1'b0;

        // R5: restart in the middle of a period
        send_lfsr(7, 0);
        do_sync();
        dtag = "R5 mid-period restart";
        send_lfsr(4*20, 0);

        // R10: gaps between strobes, ratio 60
        wr_rate(60);
        do_sync();
        dtag = "R10 gapped strobes";
        send_lfsr(5*60, 2);

        // R1 R7: largest ratio, full-scale ones
        unipolar = 1'b1;
        wr_rate(2000);
        do_sync();
        dtag = "R1 R7 ratio 2000 ones";
        for (int i = 0; i < 3*2000; i++) send(1'b1, 0);

        // R8: largest ratio, all zeros, bipolar
        unipolar = 1'b0;
        do_sync();
        dtag = "R8 ratio 2000 zeros";
        for (int i = 0; i < 3*2000; i++) send(1'b0, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule